// File: doc/BRIEF.md
# Eight-bit multi-mode barrel shifter with rotate-through-carry

This block shifts or rotates an operand word by any distance from zero to seven positions in one combinational pass. It is placed on one operand path in front of an ALU, so that a shifted operand and the ALU operation can complete in the same clock cycle. Four distance-driven modes are offered: shift left with zero fill, shift right with zero fill, shift right with sign fill, and rotate right. A fifth mode rotates right by exactly one place through an external carry bit.

The shifter is three cascaded multiplexer stages that move the word by 1, 2 and 4 places. Each stage is enabled by one bit of the distance, and each stage that fires replaces the running carry with the bit it pushes out of the word. The single-place rotate through carry bypasses the cascade. The block holds no state and has no clock. A carry-in is consumed by the one-place rotate, and it is passed through whenever nothing leaves the word.

Operation codes (3 bits): 000 shift left, 001 logical shift right, 010 arithmetic shift right, 011 rotate right, 100 rotate right through carry, 101 to 111 pass-through.

Top module: `bshift_core`

## Requirements
- R1: With operation code 000 and distance n from 1 to 7, the result is the operand moved n places toward bit 7 with zeros entering at bit 0, and carry-out is operand bit 8-n.
- R2: With operation code 001 and distance n from 1 to 7, the result is the operand moved n places toward bit 0 with zeros entering at bit 7, and carry-out is operand bit n-1.
- R3: With operation code 010 and distance n from 1 to 7, the result is the operand moved n places toward bit 0 with copies of operand bit 7 entering at the top, and carry-out is operand bit n-1.
- R4: With operation code 011 and distance n from 1 to 7, bits leaving bit 0 re-enter at bit 7 so no bit is lost, and carry-out is operand bit n-1.
- R5: With operation code 100, the result is carry-in at bit 7 above operand bits 7..1, carry-out is operand bit 0, and the distance input has no effect.
- R6: With operation codes 000 to 011 and distance 0, the result equals the operand and carry-out equals carry-in.
- R7: Operation codes 101, 110 and 111 return the operand unchanged with carry-out equal to carry-in, for every distance.
- R8: Result and carry-out are a purely combinational function of the present inputs, with no register between input and output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_i | input | 8 | Operand word to be shifted or rotated |
| amt_i | input | 3 | Shift distance, 0 to 7 |
| op_i | input | 3 | Operation code (see list above) |
| cin_i | input | 1 | Carry flag entering the shifter |
| res_o | output | 8 | Shifted or rotated word |
| cout_o | output | 1 | Last bit pushed out, or carry-in when none leaves |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies on the path (R8). The bench drives inputs just after a rising edge of its own clock and reads the outputs at the following falling edge, half a period later, so the outputs have settled. An exhaustive sweep covers all eight operation codes, all 256 operands, all eight distances and both carry-in values against a bit-by-bit reference model. Directed tasks add hand-worked corner values for each mode.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SHL  = 3'b000,
        OP_SHRL = 3'b001,
        OP_SHRA = 3'b010,
        OP_ROTR = 3'b011,
        OP_ROTC = 3'b100
    } shop_e;

endpackage

// File: rtl/bshift_opdec.sv
module bshift_opdec
    import bshift_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output logic            shift_en_o,
    output logic            rotc_sel_o,
    output shop_e           mode_o
);

    always_comb begin
        shift_en_o = 1'b0;
        rotc_sel_o = 1'b0;
        mode_o     = OP_SHL;
        unique case (op_i)
            3'b000: begin shift_en_o = 1'b1; mode_o = OP_SHL;  end
            3'b001: begin shift_en_o = 1'b1; mode_o = OP_SHRL; end
            3'b010: begin shift_en_o = 1'b1; mode_o = OP_SHRA; end
            3'b011: begin shift_en_o = 1'b1; mode_o = OP_ROTR; end
            3'b100: begin rotc_sel_o = 1'b1; mode_o = OP_ROTC; end
            default: ;
        endcase
    end

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage
    import bshift_pkg::*;
#(
    parameter int W    = 8,
    parameter int DIST = 1
) (
    input  logic [W-1:0] d_i,
    input  logic         c_i,
    input  logic         en_i,
    input  shop_e        mode_i,
    output logic [W-1:0] d_o,
    output logic         c_o
);

    always_comb begin
        d_o = d_i;
        c_o = c_i;
        if (en_i) begin
            unique case (mode_i)
                OP_SHL: begin
                    d_o = {d_i[W-DIST-1:0], {DIST{1'b0}}};
                    c_o = d_i[W-DIST];
                end
                OP_SHRL: begin
                    d_o = {{DIST{1'b0}}, d_i[W-1:DIST]};
                    c_o = d_i[DIST-1];
                end
                OP_SHRA: begin
                    d_o = {{DIST{d_i[W-1]}}, d_i[W-1:DIST]};
                    c_o = d_i[DIST-1];
                end
                OP_ROTR: begin
                    d_o = {d_i[DIST-1:0], d_i[W-1:DIST]};
                    c_o = d_i[DIST-1];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bshift_rotc.sv
module bshift_rotc #(
    parameter int W = 8
) (
    input  logic [W-1:0] d_i,
    input  logic         c_i,
    output logic [W-1:0] d_o,
    output logic         c_o
);

    always_comb begin
        d_o = {c_i, d_i[W-1:1]};
        c_o = d_i[0];
    end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
    import bshift_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);

    logic       shift_en;
    logic       rotc_sel;
    shop_e      mode;

    logic [WIDTH-1:0] chain_d [0:AMT_W];
    logic             chain_c [0:AMT_W];
    logic [WIDTH-1:0] rotc_d;
    logic             rotc_c;

    bshift_opdec dec_i (
        .op_i       (op_i),
        .shift_en_o (shift_en),
        .rotc_sel_o (rotc_sel),
        .mode_o     (mode)
    );

    assign chain_d[0] = opd_i;
    assign chain_c[0] = cin_i;

    for (genvar g = 0; g < AMT_W; g++) begin : g_stage
        bshift_stage #(
            .W    (WIDTH),
            .DIST (1 << g)
        ) stage_i (
            .d_i    (chain_d[g]),
            .c_i    (chain_c[g]),
            .en_i   (shift_en & amt_i[g]),
            .mode_i (mode),
            .d_o    (chain_d[g+1]),
            .c_o    (chain_c[g+1])
        );
    end

    bshift_rotc #(.W(WIDTH)) rotc_i (
        .d_i (opd_i),
        .c_i (cin_i),
        .d_o (rotc_d),
        .c_o (rotc_c)
    );

    always_comb begin
        if (rotc_sel) begin
            res_o  = rotc_d;
            cout_o = rotc_c;
        end else begin
            res_o  = chain_d[AMT_W];
            cout_o = chain_c[AMT_W];
        end
    end

endmodule

// File: rtl/bshift_core_chk.sv
module bshift_core_chk #(
    parameter int W     = 8,
    parameter int AMT_W = 3
) (
    input logic [W-1:0]     opd_i,
    input logic [AMT_W-1:0] amt_i,
    input logic [2:0]       op_i,
    input logic             cin_i,
    input logic [W-1:0]     res_o,
    input logic             cout_o
);

    always_comb begin
        if (op_i == 3'b000 && amt_i != '0)
            p_shl_lsb_zero_r1: assert (res_o[0] == 1'b0)
                else $error("shift left left bit 0 set");
        if (op_i == 3'b001 && amt_i != '0)
            p_shrl_msb_zero_r2: assert (res_o[W-1] == 1'b0)
                else $error("logical right shift left bit 7 set");
        if (op_i == 3'b010)
            p_shra_sign_kept_r3: assert (res_o[W-1] == opd_i[W-1])
                else $error("arithmetic right shift lost sign");
        if (op_i == 3'b011)
            p_rotr_no_loss_r4: assert ($countones(res_o) == $countones(opd_i))
                else $error("rotate right changed bit count");
        if (op_i == 3'b100)
            p_rotc_carry_r5: assert (res_o[W-1] == cin_i && cout_o == opd_i[0])
                else $error("rotate through carry wrong carry path");
        if (op_i <= 3'b011 && amt_i == '0)
            p_zero_dist_r6: assert (res_o == opd_i && cout_o == cin_i)
                else $error("zero distance altered operand");
        if (op_i > 3'b100)
            p_pass_code_r7: assert (res_o == opd_i && cout_o == cin_i)
                else $error("unused code altered operand");
    end

endmodule

bind bshift_core bshift_core_chk #(.W(WIDTH), .AMT_W(AMT_W)) chk_i (
    .opd_i  (opd_i),
    .amt_i  (amt_i),
    .op_i   (op_i),
    .cin_i  (cin_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/bshift_core_tb_top.sv
`timescale 1ns/1ps
module bshift_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opd;
    logic [2:0] amt;
    logic [2:0] op;
    logic       cin;
    logic [7:0] res;
    logic       cout;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    bshift_core dut_i (
        .opd_i  (opd),
        .amt_i  (amt),
        .op_i   (op),
        .cin_i  (cin),
        .res_o  (res),
        .cout_o (cout)
    );

    function automatic void ref_model(input logic [7:0] d, input int a,
                                      input int code, input logic c,
                                      output logic [7:0] r, output logic co);
        r  = d;
        co = c;
        case (code)
            0: for (int i = 0; i < a; i++) begin co = r[7]; r = {r[6:0], 1'b0}; end
            1: for (int i = 0; i < a; i++) begin co = r[0]; r = {1'b0, r[7:1]}; end
            2: for (int i = 0; i < a; i++) begin co = r[0]; r = {r[7], r[7:1]}; end
            3: for (int i = 0; i < a; i++) begin co = r[0]; r = {r[0], r[7:1]}; end
            4: begin co = d[0]; r = {c, d[7:1]}; end
            default: ;
        endcase
    endfunction

    task automatic apply(input logic [7:0] d, input logic [2:0] a,
                         input logic [2:0] code, input logic c);
        @(posedge clk);
        opd = d; amt = a; op = code; cin = c;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] er, input logic ec);
        total++;
        if (res !== er || cout !== ec) begin
            bad++;
            $display("FAIL %s: op=%b amt=%0d opd=%h cin=%b got res=%h cout=%b expected res=%h cout=%b",
                     tag, op, amt, opd, cin, res, cout, er, ec);
        end
    endtask

    task automatic t_zero_inputs();
        apply(8'h00, 3'd0, 3'b000, 1'b0);
        check("R8 zero inputs", 8'h00, 1'b0);
    endtask

    task automatic t_shl();
        apply(8'h81, 3'd1, 3'b000, 1'b0); check("R1 shl 81 by 1", 8'h02, 1'b1);
        apply(8'h81, 3'd7, 3'b000, 1'b0); check("R1 shl 81 by 7", 8'h80, 1'b0);
    endtask

    task automatic t_shrl();
        apply(8'h81, 3'd7, 3'b001, 1'b1); check("R2 shrl 81 by 7", 8'h01, 1'b0);
        apply(8'hF0, 3'd4, 3'b001, 1'b0); check("R2 shrl F0 by 4", 8'h0F, 1'b0);
    endtask

    task automatic t_shra();
        apply(8'h80, 3'd7, 3'b010, 1'b0); check("R3 shra 80 by 7", 8'hFF, 1'b0);
        apply(8'h40, 3'd3, 3'b010, 1'b1); check("R3 shra 40 by 3", 8'h08, 1'b0);
        apply(8'hC4, 3'd3, 3'b010, 1'b0); check("R3 shra C4 by 3", 8'hF8, 1'b1);
    endtask

    task automatic t_rotr();
        apply(8'h01, 3'd1, 3'b011, 1'b0); check("R4 rotr 01 by 1", 8'h80, 1'b1);
        apply(8'hA5, 3'd4, 3'b011, 1'b1); check("R4 rotr A5 by 4", 8'h5A, 1'b0);
    endtask

    task automatic t_rotc();
        apply(8'h01, 3'd5, 3'b100, 1'b1); check("R5 rotc 01 cin1 amt5", 8'h80, 1'b1);
        apply(8'hFE, 3'd0, 3'b100, 1'b0); check("R5 rotc FE cin0 amt0", 8'h7F, 1'b0);
        apply(8'hFE, 3'd7, 3'b100, 1'b0); check("R5 rotc FE cin0 amt7", 8'h7F, 1'b0);
    endtask

    task automatic t_zero_dist();
        apply(8'h96, 3'd0, 3'b000, 1'b0); check("R6 shl zero dist", 8'h96, 1'b0);
        apply(8'h96, 3'd0, 3'b011, 1'b1); check("R6 rotr zero dist", 8'h96, 1'b1);
    endtask

    task automatic t_pass_codes();
        apply(8'h3C, 3'd3, 3'b101, 1'b1); check("R7 code 101", 8'h3C, 1'b1);
        apply(8'h3C, 3'd7, 3'b111, 1'b0); check("R7 code 111", 8'h3C, 1'b0);
    endtask

    task automatic t_sweep();
        logic [7:0] er;
        logic       ec;
        for (int code = 0; code < 8; code++)
            for (int d = 0; d < 256; d++)
                for (int a = 0; a < 8; a++)
                    for (int c = 0; c < 2; c++) begin
                        apply(d[7:0], a[2:0], code[2:0], c[0]);
                        ref_model(d[7:0], a, code, c[0], er, ec);
                        check("R1 R2 R3 R4 R5 R6 R7 sweep", er, ec);
                    end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        opd = '0; amt = '0; op = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_zero_inputs();
        t_shl();
        t_shrl();
        t_shra();
        t_rotr();
        t_rotc();
        t_zero_dist();
        t_pass_codes();
        t_sweep();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule